// File: doc/BRIEF.md
# Word-Parallel Three-Valued Gate Evaluator

This block evaluates one basic logic gate over W independent lanes in a single clock. Each lane carries a three-valued signal (0, 1 or unknown). A W-lane operand arrives as two W-bit rail words. The first rail holds bit one of every lane and the second rail holds bit two. Because both the AND and the OR are applied rail against rail, the unknown value propagates correctly without decoding any lane. Inversion exchanges the two rails and complements them.

A caller can place W test patterns in the lanes, or W copies of a circuit that each carry a different defect, and then evaluate one gate for all of them at once. The caller presents two operands and an opcode with `in_valid`. The result and a per-lane error mask come back one clock later with `out_valid`. A lane with the unused code (1,0) is flagged and is not evaluated.

Top module: `ternary_lane_alu`

## Requirements
- R1: Lane encoding on (rail1, rail2): 0=(0,0), 1=(1,1), unknown=(0,1). The code (1,0) is illegal. Lane i uses bit i of both rails.
- R2: Opcode 3'd0 (AND) gives, per lane: 0 if either input is 0, otherwise unknown if either input is unknown, otherwise 1.
- R3: Opcode 3'd1 (OR) gives, per lane: 1 if either input is 1, otherwise unknown if either input is unknown, otherwise 0.
- R4: Opcode 3'd2 (NOT) inverts operand A per lane: 0 becomes 1, 1 becomes 0, and unknown stays unknown. Operand B is ignored.
- R5: Opcode 3'd3 (NAND) yields the inverse of AND, and opcode 3'd4 (NOR) yields the inverse of OR, both in the same single cycle.
- R6: Opcodes 3'd5 to 3'd7 copy operand A's rails to the result unchanged. Operand B is ignored.
- R7: The illegal-input rule for a lane is as follows. Operand A is checked for every opcode. Operand B is checked only for opcodes 0, 1, 3 and 4. If a checked operand is illegal in a lane, that lane's `err_mask` bit is 1 and that lane's result equals operand A's rails. Otherwise the `err_mask` bit is 0.
- R8: `out_valid` is `in_valid` delayed by one clock. The result and `err_mask` for an accepted input appear together with it.
- R9: While `in_valid` is low, `y_r1`, `y_r2` and `err_mask` hold their last values.
- R10: After reset, `out_valid`, `y_r1`, `y_r2` and `err_mask` are all 0.
- R11: Lanes are independent. A result lane depends only on that lane's inputs and the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the operands and opcode |
| op | input | 3 | Operation select |
| a_r1 | input | W | Operand A, first rail |
| a_r2 | input | W | Operand A, second rail |
| b_r1 | input | W | Operand B, first rail |
| b_r2 | input | W | Operand B, second rail |
| out_valid | output | 1 | Result valid |
| y_r1 | output | W | Result, first rail |
| y_r2 | output | W | Result, second rail |
| err_mask | output | W | One bit per lane with an illegal checked operand |

## Verification
In one cycle, normal gate evaluation in some lanes can coincide with illegal-lane pass-through in other lanes of the same word. The bench provokes this by filling each word with all sixteen combinations of the A and B lane codes, including (1,0). It does this for all eight opcodes. Every lane is then judged against a three-valued truth-table model that works on decoded lane values, not on rails. That model also decides whether operand B is checked for the opcode in use.

// File: rtl/ternary_lane_alu.sv
module ternary_lane_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] a_r1,
  input  logic [W-1:0] a_r2,
  input  logic [W-1:0] b_r1,
  input  logic [W-1:0] b_r2,
  output logic         out_valid,
  output logic [W-1:0] y_r1,
  output logic [W-1:0] y_r2,
  output logic [W-1:0] err_mask
);

  localparam logic [2:0] OP_AND  = 3'd0;
  localparam logic [2:0] OP_OR   = 3'd1;
  localparam logic [2:0] OP_NOT  = 3'd2;
  localparam logic [2:0] OP_NAND = 3'd3;
  localparam logic [2:0] OP_NOR  = 3'd4;

  logic [W-1:0] conj1, conj2, disj1, disj2;
  logic [W-1:0] res1, res2, bad, nxt1, nxt2;
  logic         two_in;

  assign conj1 = a_r1 & b_r1;
  assign conj2 = a_r2 & b_r2;
  assign disj1 = a_r1 | b_r1;
  assign disj2 = a_r2 | b_r2;

  always_comb begin
    case (op)
      OP_AND:  begin res1 = conj1;  res2 = conj2;  end
      OP_OR:   begin res1 = disj1;  res2 = disj2;  end
      OP_NOT:  begin res1 = ~a_r2;  res2 = ~a_r1;  end
      OP_NAND: begin res1 = ~conj2; res2 = ~conj1; end
      OP_NOR:  begin res1 = ~disj2; res2 = ~disj1; end
      default: begin res1 = a_r1;   res2 = a_r2;   end
    endcase
  end

  assign two_in = (op == OP_AND) || (op == OP_OR) || (op == OP_NAND) || (op == OP_NOR);
  assign bad    = (a_r1 & ~a_r2) | ((b_r1 & ~b_r2) & {W{two_in}});
  assign nxt1   = (res1 & ~bad) | (a_r1 & bad);
  assign nxt2   = (res2 & ~bad) | (a_r2 & bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y_r1      <= '0;
      y_r2      <= '0;
      err_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y_r1     <= nxt1;
        y_r2     <= nxt2;
        err_mask <= bad;
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(y_r1) && $stable(y_r2) && $stable(err_mask)));
  a_r1_legal_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((y_r1 & ~y_r2) & ~err_mask) == '0));
  a_r7_err_copies_a: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((((y_r1 ^ $past(a_r1)) | (y_r2 ^ $past(a_r2))) & err_mask) == '0));
  a_r7_a_illegal_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((($past(a_r1) & ~$past(a_r2))) & ~err_mask) == '0));

endmodule

// File: tb/tb_ternary_lane_alu.sv
`timescale 1ns/1ps
module tb_ternary_lane_alu;
  localparam int W = 32;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [W-1:0] a_r1 = '0, a_r2 = '0, b_r1 = '0, b_r2 = '0;
  logic out_valid;
  logic [W-1:0] y_r1, y_r2, err_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ternary_lane_alu #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a_r1(a_r1), .a_r2(a_r2), .b_r1(b_r1), .b_r2(b_r2),
    .out_valid(out_valid), .y_r1(y_r1), .y_r2(y_r2), .err_mask(err_mask)
  );

  localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0};
  localparam logic [W-1:0] T_A1 [NV] = '{32'hFFFF_0000, 32'h0000_00FF, 32'h0F0F_0F0F, 32'hAAAA_AAAA, 32'h0000_0000, 32'hFFFF_FFFF};
  localparam logic [W-1:0] T_A2 [NV] = '{32'hFFFF_FFFF, 32'h00FF_00FF, 32'hFF0F_0F0F, 32'hFFFF_AAAA, 32'h5555_5555, 32'hFFFF_FFFF};
  localparam logic [W-1:0] T_B1 [NV] = '{32'h0000_0000, 32'hFF00_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h3333_0000, 32'h0000_0000};
  localparam logic [W-1:0] T_B2 [NV] = '{32'h0F0F_FFFF, 32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h3333_FFFF, 32'hFFFF_FFFF};

  // lane values: 0, 1, 2 = unknown, 3 = illegal
  function automatic int dec(input logic r1, input logic r2);
    if (!r1 && !r2) return 0;
    if (r1 && r2)   return 1;
    if (!r1 && r2)  return 2;
    return 3;
  endfunction

  function automatic int t_and(input int x, input int y);
    if (x == 0 || y == 0) return 0;
    if (x == 2 || y == 2) return 2;
    return 1;
  endfunction

  function automatic int t_or(input int x, input int y);
    if (x == 1 || y == 1) return 1;
    if (x == 2 || y == 2) return 2;
    return 0;
  endfunction

  function automatic int t_not(input int x);
    if (x == 2) return 2;
    return (x == 0) ? 1 : 0;
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic model(input logic [2:0] o, input logic [W-1:0] a1, a2, b1, b2,
                       output logic [W-1:0] e1, e2, ee);
    for (int i = 0; i < W; i++) begin
      int va = dec(a1[i], a2[i]);
      int vb = dec(b1[i], b2[i]);
      bit two = (o == 3'd0) || (o == 3'd1) || (o == 3'd3) || (o == 3'd4);
      int r;
      if (va == 3 || (two && vb == 3)) begin
        e1[i] = a1[i]; e2[i] = a2[i]; ee[i] = 1'b1;
      end else begin
        case (o)
          3'd0: r = t_and(va, vb);
          3'd1: r = t_or(va, vb);
          3'd2: r = t_not(va);
          3'd3: r = t_not(t_and(va, vb));
          3'd4: r = t_not(t_or(va, vb));
          default: r = va;
        endcase
        e1[i] = (r == 1);
        e2[i] = (r != 0);
        ee[i] = 1'b0;
      end
    end
  endtask

  task automatic check(input string req, input logic ov, input logic [W-1:0] e1, e2, ee);
    n_chk++;
    if (out_valid !== ov || y_r1 !== e1 || y_r2 !== e2 || err_mask !== ee) begin
      n_bad++;
      $display("FAIL %s: got v=%0b y1=%h y2=%h err=%h, expected v=%0b y1=%h y2=%h err=%h",
               req, out_valid, y_r1, y_r2, err_mask, ov, e1, e2, ee);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] o, input logic [W-1:0] a1, a2, b1, b2);
    logic [W-1:0] e1, e2, ee;
    model(o, a1, a2, b1, b2, e1, e2, ee);
    @(negedge clk);
    op = o; a_r1 = a1; a_r2 = a2; b_r1 = b1; b_r2 = b2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, 1'b1, e1, e2, ee);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] xa1, xa2, xb1, xb2, e1, e2, ee, h1, h2, he;
    repeat (3) @(negedge clk);
    check("R10 reset", 1'b0, '0, '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 1'b0, '0, '0, '0);

    for (int k = 0; k < NV; k++)
      apply(req_of(T_OP[k]), T_OP[k], T_A1[k], T_A2[k], T_B1[k], T_B2[k]);

    // R11 / R7: every code pair in every lane group, illegal mixed with legal
    for (int i = 0; i < W; i++) begin
      xa1[i] = ((i % 4) == 1) || ((i % 4) == 3);
      xa2[i] = ((i % 4) == 1) || ((i % 4) == 2);
      xb1[i] = (((i / 4) % 4) == 1) || (((i / 4) % 4) == 3);
      xb2[i] = (((i / 4) % 4) == 1) || (((i / 4) % 4) == 2);
    end
    for (int o = 0; o < 8; o++) begin
      apply($sformatf("%s R7 R11 op%0d", req_of(3'(o)), o), 3'(o), xa1, xa2, xb1, xb2);
      apply($sformatf("%s R7 R11 swap op%0d", req_of(3'(o)), o), 3'(o), xb1, xb2, xa1, xa2);
    end

    // R4 / R6: operand B has no effect on unary and reserved codes
    apply("R4 b ignored", 3'd2, xa1, xa2, 32'hFFFF_FFFF, 32'h0000_0000);
    apply("R6 b ignored", 3'd6, xa1, xa2, 32'hFFFF_FFFF, 32'h0000_0000);

    // R9: hold while idle, with inputs moving
    model(3'd1, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0, 32'h0F0F_0000, h1, h2, he);
    apply("R3 before hold", 3'd1, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0, 32'h0F0F_0000);
    op = 3'd3; a_r1 = 32'hFFFF_FFFF; a_r2 = 32'h0; b_r1 = '1; b_r2 = '0;
    repeat (3) @(negedge clk);
    check("R9 hold", 1'b0, h1, h2, he);

    // R8: back-to-back valid inputs, one result per clock
    model(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'h00FF_FFFF, e1, e2, ee);
    model(3'd4, 32'h0, 32'h0000_FFFF, 32'h0, 32'hFF00_0000, h1, h2, he);
    @(negedge clk);
    op = 3'd0; a_r1 = '1; a_r2 = '1; b_r1 = 32'h00FF_00FF; b_r2 = 32'h00FF_FFFF; in_valid = 1'b1;
    @(negedge clk);
    check("R8 first of pair", 1'b1, e1, e2, ee);
    op = 3'd4; a_r1 = '0; a_r2 = 32'h0000_FFFF; b_r1 = '0; b_r2 = 32'hFF00_0000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second of pair", 1'b1, h1, h2, he);
    @(negedge clk);
    check("R8 valid drops", 1'b0, h1, h2, he);

    // R1: all-unknown word stays unknown through AND with all ones
    apply("R1 unknown lanes", 3'd0, '0, '1, '1, '1);

    // R10: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 re-reset", 1'b0, '0, '0, '0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule